// File: doc/BRIEF.md
# EEPROM Page-Write Column Latch Controller

This block sits between a CPU's external-data access port and a 2-Kbyte EEPROM array. While a control enable is set, the low 2 Kbytes of the external-data space map to the EEPROM. Reads are passed to the array, and the stored byte comes back one cycle later. Writes never reach the array directly. Each write lands in a 128-byte column latch, and the latch byte is marked as loaded by a ninth flag bit.

A separate program command starts the sequencer. It walks all 128 latch columns of the pending row and writes to the array only the columns whose flag is set. It then holds busy for a programmable settle time and clears every flag. One byte, a full page or any subset of a page can therefore be programmed, and the untouched bytes of the row keep their contents. While busy is high, the CPU side is locked out.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, busy, rd_valid and arr_we are all low, and no latch column is flagged.
- R2: An access is accepted only when ee_en is 1 and cpu_addr[15:11] is zero. Any other write leaves no flag, and any other read produces no rd_valid pulse.
- R3: An accepted read of address A asserts rd_valid in the next cycle, with cpu_rdata equal to the array byte at A[10:0].
- R4: An accepted write stores cpu_wdata in latch column cpu_addr[6:0] and sets that column's flag. It also sets the pending row to cpu_addr[10:7]. A later write to another row replaces the pending row, and columns already flagged stay flagged.
- R5: Programming writes each flagged column c to array address {row, c}. No other array location changes, and arr_we is never high outside programming.
- R6: A program command with at least one flagged column raises busy in the next cycle. Busy then stays high for exactly 128 + HOLD_CYC cycles.
- R7: When programming ends, all flags are clear, so an immediate second program command does nothing.
- R8: A program command with no flagged column leaves busy low and performs no array write.
- R9: While busy, CPU writes, CPU reads and program commands are ignored.
- R10: Writing the same column twice before programming programs the last value written.
- R11: Programming a single byte and programming a full 128-byte page both work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ee_en | input | 1 | Control enable that maps the EEPROM into the data space |
| cpu_addr | input | 16 | External-data address |
| cpu_wr | input | 1 | Write strobe, one cycle |
| cpu_rd | input | 1 | Read strobe, one cycle |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted read |
| prog_start | input | 1 | Program command for the pending row |
| busy | output | 1 | Programming in progress |
| arr_addr | output | 11 | Array address (CPU address when idle, row/column when programming) |
| arr_wdata | output | 8 | Array write data |
| arr_we | output | 1 | Array write enable |
| arr_rdata | input | 8 | Array read data, asynchronous to arr_addr |

## Verification
The hardest situation to reach is a write to one row followed by writes to a different row before programming. Flags set under the old row must then land in the new row, and the old row must stay untouched. The stimulus table mixes two rows, one column written twice, and the last column of the page. The bench then reads both rows back in full. A second case is CPU traffic arriving in the middle of the busy window. The bench issues a write, a read and another program command while the sequencer is scanning. It then shows through a later empty program and a readback that none of them took effect.

// File: rtl/eepw_pkg.sv
// Package: shared types for the EEPROM page-write controller.
// Assumes: nothing beyond IEEE 1800-2017.
package eepw_pkg;

    // Sequencer phases: idle, column scan (array writes), settle hold.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_SCAN = 2'd1,
        SEQ_HOLD = 2'd2
    } seq_state_t;

endpackage

// File: rtl/eepw_cpu_port.sv
// Module: eepw_cpu_port
// Decodes CPU accesses into the EEPROM window and registers read data.
// Assumes: the array read is asynchronous to arr_addr, and the strobes are
// one cycle wide. Accesses are refused while busy.
module eepw_cpu_port #(
    parameter int XA_W   = 16,
    parameter int EE_AW  = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ee_en,
    input  logic [XA_W-1:0]   cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic              busy,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              acc_ok,
    output logic              lat_we,
    output logic              rd_req,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              rd_valid
);

    localparam int HI_W = XA_W - EE_AW;

    // Window decode: enable set, upper address bits zero, sequencer idle.
    always_comb begin
        acc_ok = ee_en && (cpu_addr[XA_W-1:EE_AW] == HI_W'(0)) && !busy;
        lat_we = cpu_wr && acc_ok;
        rd_req = cpu_rd && acc_ok;
    end

    // Capture the array byte for an accepted read and flag it valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            cpu_rdata <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) begin
                cpu_rdata <= arr_rdata;
            end
        end
    end

endmodule

// File: rtl/eepw_col_latch.sv
// Module: eepw_col_latch
// Holds one page of column data, with a loaded flag per column and the
// pending row number.
// Assumes: a clear and a load never arrive in the same cycle (the load is
// blocked while busy). Data bytes carry no reset, because only flagged
// bytes are ever used.
module eepw_col_latch #(
    parameter int PAGE   = 128,
    parameter int COL_W  = 7,
    parameter int ROW_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_we,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_flags,
    input  logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_flag,
    output logic              any_flag,
    output logic [ROW_W-1:0]  row
);

    logic [PAGE-1:0]   flag_q;
    logic [DATA_W-1:0] data_q [PAGE];

    for (genvar c = 0; c < PAGE; c++) begin : g_col
        // Per-column flag: set on load, cleared at the end of programming.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[c] <= 1'b0;
            end else if (clr_flags) begin
                flag_q[c] <= 1'b0;
            end else if (lat_we && (wr_col == COL_W'(c))) begin
                flag_q[c] <= 1'b1;
            end
        end

        // Per-column data byte: last write wins.
        always_ff @(posedge clk) begin
            if (lat_we && (wr_col == COL_W'(c))) begin
                data_q[c] <= wr_data;
            end
        end
    end

    // Pending row follows the most recent accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
        end else if (lat_we) begin
            row <= wr_row;
        end
    end

    // Column read-out for the sequencer, and the page-level flag summary.
    always_comb begin
        rd_data  = data_q[rd_col];
        rd_flag  = flag_q[rd_col];
        any_flag = |flag_q;
    end

endmodule

// File: rtl/eepw_prog_seq.sv
// Module: eepw_prog_seq
// Row programming sequencer. It scans every column once, requests an array
// write for each flagged column, holds busy for HOLD_CYC settle cycles and
// then clears the flags.
// Assumes: HOLD_CYC >= 1. A command with no flag set is dropped.
module eepw_prog_seq #(
    parameter int PAGE     = 128,
    parameter int COL_W    = 7,
    parameter int HOLD_CYC = 64,
    parameter int HC_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_start,
    input  logic             any_flag,
    input  logic             col_flag,
    output logic             busy,
    output logic [COL_W-1:0] scan_col,
    output logic             arr_we,
    output logic             clr_flags
);

    import eepw_pkg::*;

    seq_state_t      state_q;
    logic [HC_W-1:0] hold_q;
    logic            last_col;
    logic            hold_done;

    // End-of-phase conditions.
    always_comb begin
        last_col  = (scan_col == COL_W'(PAGE - 1));
        hold_done = (hold_q == HC_W'(HOLD_CYC - 1));
    end

    // Phase register together with the column and hold counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            scan_col <= '0;
            hold_q   <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (prog_start && any_flag) begin
                        state_q  <= SEQ_SCAN;
                        scan_col <= '0;
                    end
                end
                SEQ_SCAN: begin
                    if (last_col) begin
                        state_q <= SEQ_HOLD;
                        hold_q  <= '0;
                    end else begin
                        scan_col <= scan_col + COL_W'(1);
                    end
                end
                SEQ_HOLD: begin
                    if (hold_done) begin
                        state_q <= SEQ_IDLE;
                    end else begin
                        hold_q <= hold_q + HC_W'(1);
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Outputs decoded from the phase.
    always_comb begin
        busy      = (state_q != SEQ_IDLE);
        arr_we    = (state_q == SEQ_SCAN) && col_flag;
        clr_flags = (state_q == SEQ_HOLD) && hold_done;
    end

endmodule

// File: rtl/eeprom_page_writer.sv
// Module: eeprom_page_writer (top)
// EEPROM write buffer and row programmer. CPU writes fill a flagged column
// latch, and a program command moves only the flagged bytes into one row.
// Assumes: the array port has an asynchronous read and a single-cycle write.
// Array timing is modelled only as a fixed hold count.
module eeprom_page_writer #(
    parameter int XA_W       = 16,
    parameter int DATA_W     = 8,
    parameter int EE_BYTES   = 2048,
    parameter int PAGE_BYTES = 128,
    parameter int HOLD_CYC   = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ee_en,
    input  logic [XA_W-1:0]              cpu_addr,
    input  logic                         cpu_wr,
    input  logic                         cpu_rd,
    input  logic [DATA_W-1:0]            cpu_wdata,
    output logic [DATA_W-1:0]            cpu_rdata,
    output logic                         rd_valid,
    input  logic                         prog_start,
    output logic                         busy,
    output logic [$clog2(EE_BYTES)-1:0]  arr_addr,
    output logic [DATA_W-1:0]            arr_wdata,
    output logic                         arr_we,
    input  logic [DATA_W-1:0]            arr_rdata
);

    localparam int EE_AW = $clog2(EE_BYTES);
    localparam int COL_W = $clog2(PAGE_BYTES);
    localparam int ROW_W = EE_AW - COL_W;
    localparam int HC_W  = $clog2(HOLD_CYC + 1);

    logic             acc_ok;
    logic             lat_we;
    logic             rd_req;
    logic             any_flag;
    logic             col_flag;
    logic             clr_flags;
    logic [COL_W-1:0] scan_col;
    logic [ROW_W-1:0] row;

    eepw_cpu_port #(
        .XA_W   (XA_W),
        .EE_AW  (EE_AW),
        .DATA_W (DATA_W)
    ) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .ee_en     (ee_en),
        .cpu_addr  (cpu_addr),
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .busy      (busy),
        .arr_rdata (arr_rdata),
        .acc_ok    (acc_ok),
        .lat_we    (lat_we),
        .rd_req    (rd_req),
        .cpu_rdata (cpu_rdata),
        .rd_valid  (rd_valid)
    );

    eepw_col_latch #(
        .PAGE   (PAGE_BYTES),
        .COL_W  (COL_W),
        .ROW_W  (ROW_W),
        .DATA_W (DATA_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .lat_we    (lat_we),
        .wr_col    (cpu_addr[COL_W-1:0]),
        .wr_row    (cpu_addr[EE_AW-1:COL_W]),
        .wr_data   (cpu_wdata),
        .clr_flags (clr_flags),
        .rd_col    (scan_col),
        .rd_data   (arr_wdata),
        .rd_flag   (col_flag),
        .any_flag  (any_flag),
        .row       (row)
    );

    eepw_prog_seq #(
        .PAGE     (PAGE_BYTES),
        .COL_W    (COL_W),
        .HOLD_CYC (HOLD_CYC),
        .HC_W     (HC_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_start (prog_start),
        .any_flag   (any_flag),
        .col_flag   (col_flag),
        .busy       (busy),
        .scan_col   (scan_col),
        .arr_we     (arr_we),
        .clr_flags  (clr_flags)
    );

    // Array address mux: sequencer row/column while busy, CPU address otherwise.
    always_comb begin
        arr_addr = busy ? {row, scan_col} : cpu_addr[EE_AW-1:0];
    end

endmodule

// File: rtl/eepw_checker.sv
// Module: eepw_checker
// Temporal checks on the page-write controller, bound into the top.
// Assumes: it is bound to eeprom_page_writer, with internal decode and flag
// signals connected by name.
module eepw_checker #(
    parameter int EE_AW = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             arr_we,
    input logic [EE_AW-1:0] arr_addr,
    input logic             prog_start,
    input logic             any_flag,
    input logic             cpu_rd,
    input logic             rd_req,
    input logic             rd_valid
);

    assert_idle_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !arr_we);

    assert_row_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(arr_addr[EE_AW-1:EE_AW-4]));

    assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_start && !busy && any_flag) |=> busy);

    assert_empty_noop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_start && !busy && !any_flag) |=> !busy);

    assert_flags_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !any_flag);

    assert_read_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    assert_busy_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cpu_rd) |=> !rd_valid);

endmodule

bind eeprom_page_writer eepw_checker #(.EE_AW(EE_AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .arr_we     (arr_we),
    .arr_addr   (arr_addr),
    .prog_start (prog_start),
    .any_flag   (any_flag),
    .cpu_rd     (cpu_rd),
    .rd_req     (rd_req),
    .rd_valid   (rd_valid)
);

// File: tb/eeprom_page_writer_bench.sv
// Bench for eeprom_page_writer. An array model sits on the memory port, and
// a shadow of the expected array contents is kept from the requirements.
module eeprom_page_writer_bench;

    localparam int HOLD = 20;
    localparam int PAGE = 128;
    localparam int BUSY_LEN = PAGE + HOLD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ee_en = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        rd_valid;
    logic        prog_start = 1'b0;
    logic        busy;
    logic [10:0] arr_addr;
    logic [7:0]  arr_wdata;
    logic        arr_we;
    logic [7:0]  arr_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    int wr_cnt = 0;

    logic [7:0] mem    [2048];
    logic [7:0] shadow [2048];
    logic [7:0] pend_d [PAGE];
    logic       pend_f [PAGE];
    logic [3:0] pend_row;

    always #10 clk = ~clk;

    eeprom_page_writer #(.HOLD_CYC(HOLD)) u_eeprom_page_writer (
        .clk(clk), .rst_n(rst_n), .ee_en(ee_en), .cpu_addr(cpu_addr),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .rd_valid(rd_valid), .prog_start(prog_start),
        .busy(busy), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_we(arr_we), .arr_rdata(arr_rdata)
    );

    // Array model: asynchronous read, write on the clock, initial pattern at reset.
    assign arr_rdata = mem[arr_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2048; i++) mem[i] <= 8'(i) ^ 8'hA5 ^ 8'(i >> 8);
        end else if (arr_we) begin
            mem[arr_addr] <= arr_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    typedef struct packed {
        logic [15:0] a;
        logic [7:0]  d;
    } vec_t;

    // Mixed rows, a repeated column and the last column of the page.
    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{16'h0100, 8'h11}, '{16'h0105, 8'h22}, '{16'h0105, 8'h33},
        '{16'h017F, 8'h44}, '{16'h0190, 8'h55}, '{16'h0102, 8'h66},
        '{16'h01C0, 8'h77}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic clear_pend();
        for (int c = 0; c < PAGE; c++) pend_f[c] = 1'b0;
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, input bit take);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        if (take) begin
            pend_d[a[6:0]] = d;
            pend_f[a[6:0]] = 1'b1;
            pend_row = a[10:7];
        end
    endtask

    task automatic cpu_read(input logic [15:0] a, output logic v, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        v = rd_valid;
        d = cpu_rdata;
    endtask

    // Issue a program command, measure busy, and commit the shadow model.
    task automatic do_program(input string req);
        int bcyc = 0;
        int nflag = 0;
        int w0 = wr_cnt;
        for (int c = 0; c < PAGE; c++) if (pend_f[c]) nflag++;
        @(negedge clk);
        prog_start = 1'b1;
        @(negedge clk);
        prog_start = 1'b0;
        while (busy && bcyc < 1000) begin
            bcyc++;
            @(negedge clk);
        end
        check(bcyc == ((nflag > 0) ? BUSY_LEN : 0), {req, " busy length R6"},
              bcyc, (nflag > 0) ? BUSY_LEN : 0);
        check((wr_cnt - w0) == nflag, {req, " array write count R5"}, wr_cnt - w0, nflag);
        for (int c = 0; c < PAGE; c++) if (pend_f[c]) shadow[{pend_row, 7'(c)}] = pend_d[c];
        clear_pend();
    endtask

    task automatic check_row(input logic [3:0] r, input string req);
        logic v;
        logic [7:0] d;
        for (int c = 0; c < PAGE; c++) begin
            cpu_read({5'b0, r, 7'(c)}, v, d);
            check(v == 1'b1, {req, " rd_valid R3"}, v, 1);
            check(d == shadow[{r, 7'(c)}], {req, " readback R3 R5"}, d, shadow[{r, 7'(c)}]);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic v;
        logic [7:0] d;
        int w0;
        for (int i = 0; i < 2048; i++) shadow[i] = 8'(i) ^ 8'hA5 ^ 8'(i >> 8);
        clear_pend();
        pend_row = '0;
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
        check(arr_we == 1'b0, "R1 arr_we", arr_we, 0);
        rst_n = 1'b1;
        ee_en = 1'b1;
        @(negedge clk);

        // R8 and R1: nothing is flagged after reset, so a command is a no-op.
        do_program("R8 empty after reset");

        // Table walk: R4 row replacement, R10 overwrite, R5 partial page.
        for (int i = 0; i < NV; i++) cpu_write(VEC[i].a, VEC[i].d, 1'b1);
        do_program("R4 R10 table");
        check_row(4'd3, "R4 R10 row3");
        check_row(4'd2, "R5 row2 untouched");

        // R7: flags cleared, second command does nothing.
        do_program("R7 second command");

        // R11: single byte.
        cpu_write(16'h07A3, 8'h5C, 1'b1);
        do_program("R11 single byte");
        check_row(4'hF, "R11 single byte row");

        // R11: full page.
        for (int c = 0; c < PAGE; c++) cpu_write(16'(c), 8'(c * 3 + 1), 1'b1);
        do_program("R11 full page");
        check_row(4'd0, "R11 full page row");

        // R9: traffic while busy is ignored.
        cpu_write(16'h0281, 8'hC3, 1'b1);
        w0 = wr_cnt;
        @(negedge clk);
        prog_start = 1'b1;
        @(negedge clk);
        prog_start = 1'b0;
        check(busy == 1'b1, "R9 busy raised R6", busy, 1);
        cpu_write(16'h0285, 8'hEE, 1'b0);
        cpu_read(16'h0100, v, d);
        check(v == 1'b0, "R9 read during busy", v, 0);
        @(negedge clk);
        prog_start = 1'b1;
        @(negedge clk);
        prog_start = 1'b0;
        while (busy) @(negedge clk);
        check((wr_cnt - w0) == 1, "R9 one array write", wr_cnt - w0, 1);
        shadow[11'h281] = 8'hC3;
        clear_pend();
        do_program("R9 ignored write left no flag");
        check_row(4'd5, "R9 row5");

        // R2: decode gating.
        ee_en = 1'b0;
        cpu_write(16'h0300, 8'h99, 1'b0);
        cpu_read(16'h0300, v, d);
        check(v == 1'b0, "R2 read with enable low", v, 0);
        ee_en = 1'b1;
        cpu_write(16'h0900, 8'h98, 1'b0);
        cpu_read(16'h0900, v, d);
        check(v == 1'b0, "R2 read out of window", v, 0);
        do_program("R2 rejected writes");
        check_row(4'd6, "R2 row6");

        summary();
        $finish;
    end

endmodule